// File: doc/BRIEF.md
# Interruptible Repeated Byte-Move Sequencer

This block executes one repeated byte-copy instruction. It fetches code bytes from the code segment at the instruction pointer and accepts any number of segment-override and repeat prefixes, followed by the byte-move opcode. It then copies bytes one at a time from a source segment:offset to the extra segment at the destination offset. Each copy is one atomic element. The element moves one byte, decrements the count when the repeat prefix is present, steps both indexes in the direction selected by the direction flag, and then tests the count.

Between elements the sequencer samples a maskable interrupt request. When it accepts one, it stops and reports a restart address together with the live count and indexes, so that the caller can resume the instruction later. The restart address is the offset of the repeat prefix. A segment override placed in front of that prefix is therefore not decoded again on resume, and the source falls back to the data segment. The block reproduces this behaviour on purpose. An override placed after the repeat prefix is decoded again on every resume.

Top module: `strmov_seq`

## Requirements
- R1: Code bytes are read in order from physical address CS:IP. The byte values are decoded as follows: 0x26, 0x2E, 0x36 and 0x3E select the source segment ES, CS, SS and DS respectively (opcode bits 4:3 give 0 to 3). 0xF3 is the repeat prefix. 0xA4 is the byte-move opcode. With no override, the source segment is DS.
- R2: Each element reads one byte from source segment:SI and writes it to ES:DI. Under a repeat prefix the count then drops by one. Bytes next to the moved range are not written.
- R3: SI and DI step together: by +1 when df_i is 0 and by -1 when df_i is 1, wrapping at 16 bits.
- R4: Physical address = segment*16 + offset, truncated to 20 bits.
- R5: An interrupt is accepted only after a complete element, when irq_i and if_i are both 1 and the count is nonzero. Acceptance gives an intr_o pulse, ip_o = offset of the repeat prefix, and cx_o, si_o and di_o as left by the completed elements.
- R6: With if_i at 0, the repetition runs to completion whatever irq_i does, and any override stays in effect for every element.
- R7: Restarting at the reported address does not re-decode an override that preceded the repeat prefix, so later elements read from DS. An override that follows the repeat prefix stays in effect.
- R8: With a repeat prefix and a count of zero at the opcode, no byte is moved and done_o pulses.
- R9: At completion done_o pulses with ip_o = opcode offset + 1. When the count reaches zero, no interrupt is reported, even with irq_i and if_i at 1.
- R10: Without a repeat prefix exactly one element runs, the count is unchanged, and no interrupt is taken.
- R11: Any other code byte ends the sequence with an unsup_o pulse, ip_o = that byte's offset, and no memory write.
- R12: The memory port returns read data one cycle after mem_rd_o. mem_rd_o and mem_wr_o are never high together. Each write immediately follows a read. Completion pulses occur only with busy_o at 0.
- R13: After reset the block is idle, with no strobes and no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction at ip_i when idle |
| ip_i | input | 16 | Starting instruction offset |
| cx_i | input | 16 | Starting count |
| si_i | input | 16 | Starting source offset |
| di_i | input | 16 | Starting destination offset |
| cs_i | input | 16 | Code segment |
| ds_i | input | 16 | Data segment |
| es_i | input | 16 | Extra segment (destination) |
| ss_i | input | 16 | Stack segment |
| df_i | input | 1 | Direction flag, 1 = decrement |
| if_i | input | 1 | Interrupt enable |
| irq_i | input | 1 | Maskable interrupt request |
| mem_addr_o | output | 20 | Memory byte address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, one cycle after mem_rd_o |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Completion pulse |
| intr_o | output | 1 | Interrupt accepted pulse |
| unsup_o | output | 1 | Unsupported code byte pulse |
| ip_o | output | 16 | Next or restart instruction offset |
| cx_o | output | 16 | Current count |
| si_o | output | 16 | Current source offset |
| di_o | output | 16 | Current destination offset |

## Verification
At the test after the last element, two events can fall in the same cycle: the count reaching zero and an accepted interrupt. The bench holds irq_i and if_i high for the whole repetition and resumes after every stop. Each element then ends in an interrupt except the final one. The bench judges the result by the number of intr_o pulses (count minus one), by done_o with the post-opcode address, and by which segment each copied byte came from.

// File: rtl/strmov_pkg.sv
package strmov_pkg;
  localparam int NUM_SEG = 4;
  localparam int DATA_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_READ, ST_WRITE, ST_TEST
  } st_e;

  // encoding equals override opcode bits 4:3
  typedef enum logic [1:0] {
    SEG_ES = 2'd0, SEG_CS = 2'd1, SEG_SS = 2'd2, SEG_DS = 2'd3
  } seg_e;

  typedef enum logic [1:0] {
    CLS_OVR, CLS_REP, CLS_MOV, CLS_OTHER
  } cls_e;

  localparam logic [DATA_W-1:0] OPC_REP  = 8'hF3;
  localparam logic [DATA_W-1:0] OPC_MOVB = 8'hA4;
  localparam logic [2:0]        OVR_HI   = 3'b001;
  localparam logic [2:0]        OVR_LO   = 3'b110;
endpackage

// File: rtl/strmov_dec.sv
module strmov_dec
  import strmov_pkg::*;
(
  input  logic [DATA_W-1:0] code_i,
  output cls_e              cls_o,
  output seg_e              seg_o
);
  always_comb begin
    seg_o = seg_e'(code_i[4:3]);
    if (code_i[7:5] == OVR_HI && code_i[2:0] == OVR_LO) cls_o = CLS_OVR;
    else if (code_i == OPC_REP)                          cls_o = CLS_REP;
    else if (code_i == OPC_MOVB)                         cls_o = CLS_MOV;
    else                                                 cls_o = CLS_OTHER;
  end
endmodule

// File: rtl/strmov_agu.sv
module strmov_agu #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W    = 20,
  parameter int NSEG      = 4,
  localparam int SEL_W    = $clog2(NSEG),
  localparam int SUM_W    = OFS_W + SEG_SHIFT
) (
  input  logic [NSEG-1:0][OFS_W-1:0] seg_tab_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [OFS_W-1:0]           off_i,
  output logic [ADDR_W-1:0]          addr_o
);
  logic [OFS_W-1:0] seg;
  logic [SUM_W-1:0] sum;

  assign seg = seg_tab_i[sel_i];
  assign sum = (SUM_W'(seg) << SEG_SHIFT) + SUM_W'(off_i);

  generate
    if (ADDR_W == SUM_W) begin : g_exact
      assign addr_o = sum;
    end else if (ADDR_W < SUM_W) begin : g_trunc
      assign addr_o = sum[ADDR_W-1:0];
    end else begin : g_wide
      assign addr_o = ADDR_W'(sum);
    end
  endgenerate
endmodule

// File: rtl/strmov_idx.sv
module strmov_idx #(
  parameter int OFS_W = 16
) (
  input  logic [OFS_W-1:0] si_i,
  input  logic [OFS_W-1:0] di_i,
  input  logic [OFS_W-1:0] cx_i,
  input  logic             df_i,
  input  logic             rep_i,
  output logic [OFS_W-1:0] si_o,
  output logic [OFS_W-1:0] di_o,
  output logic [OFS_W-1:0] cx_o
);
  localparam logic [OFS_W-1:0] STEP_UP = OFS_W'(1);
  localparam logic [OFS_W-1:0] STEP_DN = '1;

  logic [OFS_W-1:0] step;

  assign step = df_i ? STEP_DN : STEP_UP;
  assign si_o = si_i + step;
  assign di_o = di_i + step;
  assign cx_o = rep_i ? cx_i + STEP_DN : cx_i;
endmodule

// File: rtl/strmov_seq.sv
module strmov_seq
  import strmov_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int ADDR_W   = OFS_W + SEG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OFS_W-1:0]  ip_i,
  input  logic [OFS_W-1:0]  cx_i,
  input  logic [OFS_W-1:0]  si_i,
  input  logic [OFS_W-1:0]  di_i,
  input  logic [OFS_W-1:0]  cs_i,
  input  logic [OFS_W-1:0]  ds_i,
  input  logic [OFS_W-1:0]  es_i,
  input  logic [OFS_W-1:0]  ss_i,
  input  logic              df_i,
  input  logic              if_i,
  input  logic              irq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              intr_o,
  output logic              unsup_o,
  output logic [OFS_W-1:0]  ip_o,
  output logic [OFS_W-1:0]  cx_o,
  output logic [OFS_W-1:0]  si_o,
  output logic [OFS_W-1:0]  di_o
);
  localparam logic [OFS_W-1:0] IP_INC = OFS_W'(1);

  st_e              state_q;
  seg_e             src_sel_q;
  logic             rep_q;
  logic [OFS_W-1:0] ip_q, rep_ip_q, cx_q, si_q, di_q;
  logic             done_q, intr_q, unsup_q;

  cls_e             dec_cls;
  seg_e             dec_seg;
  seg_e             agu_sel;
  logic [OFS_W-1:0] agu_off;
  logic [OFS_W-1:0] nxt_si, nxt_di, nxt_cx;
  logic [NUM_SEG-1:0][OFS_W-1:0] seg_tab;

  always_comb begin
    seg_tab         = '0;
    seg_tab[SEG_ES] = es_i;
    seg_tab[SEG_CS] = cs_i;
    seg_tab[SEG_SS] = ss_i;
    seg_tab[SEG_DS] = ds_i;
  end

  strmov_dec u_dec (
    .code_i (mem_rdata_i),
    .cls_o  (dec_cls),
    .seg_o  (dec_seg)
  );

  always_comb begin
    case (state_q)
      ST_FETCH: begin agu_sel = SEG_CS;    agu_off = ip_q; end
      ST_READ:  begin agu_sel = src_sel_q; agu_off = si_q; end
      default:  begin agu_sel = SEG_ES;    agu_off = di_q; end
    endcase
  end

  strmov_agu #(
    .OFS_W     (OFS_W),
    .SEG_SHIFT (SEG_SHIFT),
    .ADDR_W    (ADDR_W),
    .NSEG      (NUM_SEG)
  ) u_agu (
    .seg_tab_i (seg_tab),
    .sel_i     (agu_sel),
    .off_i     (agu_off),
    .addr_o    (mem_addr_o)
  );

  strmov_idx #(.OFS_W(OFS_W)) u_idx (
    .si_i  (si_q),
    .di_i  (di_q),
    .cx_i  (cx_q),
    .df_i  (df_i),
    .rep_i (rep_q),
    .si_o  (nxt_si),
    .di_o  (nxt_di),
    .cx_o  (nxt_cx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      src_sel_q <= SEG_DS;
      rep_q     <= 1'b0;
      ip_q      <= '0;
      rep_ip_q  <= '0;
      cx_q      <= '0;
      si_q      <= '0;
      di_q      <= '0;
      done_q    <= 1'b0;
      intr_q    <= 1'b0;
      unsup_q   <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      intr_q  <= 1'b0;
      unsup_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          ip_q      <= ip_i;
          cx_q      <= cx_i;
          si_q      <= si_i;
          di_q      <= di_i;
          src_sel_q <= SEG_DS;
          rep_q     <= 1'b0;
          state_q   <= ST_FETCH;
        end
        ST_FETCH: state_q <= ST_DECODE;
        ST_DECODE: begin
          case (dec_cls)
            CLS_OVR: begin
              src_sel_q <= dec_seg;
              ip_q      <= ip_q + IP_INC;
              state_q   <= ST_FETCH;
            end
            CLS_REP: begin
              rep_q    <= 1'b1;
              rep_ip_q <= ip_q;  // restart lands here, earlier prefixes lost
              ip_q     <= ip_q + IP_INC;
              state_q  <= ST_FETCH;
            end
            CLS_MOV: begin
              ip_q <= ip_q + IP_INC;
              if (rep_q && cx_q == '0) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_READ;
              end
            end
            default: begin
              unsup_q <= 1'b1;
              state_q <= ST_IDLE;
            end
          endcase
        end
        ST_READ: state_q <= ST_WRITE;
        ST_WRITE: begin
          si_q    <= nxt_si;
          di_q    <= nxt_di;
          cx_q    <= nxt_cx;
          state_q <= ST_TEST;
        end
        ST_TEST: begin
          if (!rep_q || cx_q == '0) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (irq_i && if_i) begin
            intr_q  <= 1'b1;
            ip_q    <= rep_ip_q;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_READ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_o    = (state_q == ST_FETCH) || (state_q == ST_READ);
  assign mem_wr_o    = (state_q == ST_WRITE);
  assign mem_wdata_o = mem_rdata_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign intr_o      = intr_q;
  assign unsup_o     = unsup_q;
  assign ip_o        = ip_q;
  assign cx_o        = cx_q;
  assign si_o        = si_q;
  assign di_o        = di_q;
endmodule

// File: rtl/strmov_chk.sv
module strmov_chk #(
  parameter int OFS_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mem_rd_o,
  input logic             mem_wr_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             intr_o,
  input logic             unsup_o,
  input logic [OFS_W-1:0] cx_o,
  input logic [OFS_W-1:0] si_o,
  input logic [OFS_W-1:0] di_o,
  input logic             df_i,
  input logic             if_i,
  input logic             irq_i
);
  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R12
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> $past(mem_rd_o)); // R12
  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || intr_o || unsup_o) |-> !busy_o); // R12
  AST_END_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, intr_o, unsup_o})); // R9
  AST_INTR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |-> ($past(irq_i) && $past(if_i))); // R5
  AST_INTR_CNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |-> (cx_o != '0)); // R9
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> (OFS_W'($past(cx_o) - cx_o) <= ONE)); // R2
  AST_IDX_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> (OFS_W'(si_o - $past(si_o)) == OFS_W'(di_o - $past(di_o)))); // R3
  AST_IDX_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !df_i) |=> (si_o == OFS_W'($past(si_o) + ONE))); // R3
  AST_IDX_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && df_i) |=> (si_o == OFS_W'($past(si_o) - ONE))); // R3
endmodule

bind strmov_seq strmov_chk #(.OFS_W(OFS_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mem_rd_o (mem_rd_o),
  .mem_wr_o (mem_wr_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .intr_o   (intr_o),
  .unsup_o  (unsup_o),
  .cx_o     (cx_o),
  .si_o     (si_o),
  .di_o     (di_o),
  .df_i     (df_i),
  .if_i     (if_i),
  .irq_i    (irq_i)
);

// File: tb/tb_strmov_seq.sv
`timescale 1ns/1ps
module tb_strmov_seq;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start, df, ife, irq;
  logic [15:0] ip_in, cx_in, si_in, di_in;
  logic [15:0] cs = 16'h1000, ds = 16'h2000, es = 16'h3000, ss = 16'h5000;
  logic [19:0] mem_addr;
  logic        mem_rd, mem_wr, busy, done, intr, unsup;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] ip_out, cx_out, si_out, di_out;

  strmov_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ip_i(ip_in), .cx_i(cx_in),
    .si_i(si_in), .di_i(di_in), .cs_i(cs), .ds_i(ds), .es_i(es), .ss_i(ss),
    .df_i(df), .if_i(ife), .irq_i(irq), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .intr_o(intr), .unsup_o(unsup),
    .ip_o(ip_out), .cx_o(cx_out), .si_o(si_out), .di_o(di_out)
  );

  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction
  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return ({4'h0, s} << 4) + {4'h0, o};
  endfunction
  function automatic logic [15:0] stepoff(input logic [15:0] b, input logic d, input int k);
    return d ? b - 16'(k) : b + 16'(k);
  endfunction

  logic [7:0]  mem [0:(1<<20)-1];
  logic        tb_we = 1'b0, tb_init = 1'b0;
  logic [19:0] tb_wa = '0;
  logic [7:0]  tb_wd = '0;

  always @(posedge clk) begin
    if (tb_init) for (int a = 0; a < (1 << 20); a++) mem[a] <= pat(20'(a));
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
    else if (tb_we) mem[tb_wa] <= tb_wd;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic mwrite(input logic [19:0] a, input logic [7:0] d);
    tb_wa = a; tb_wd = d; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  bit got_done, got_intr, got_unsup, wr_seen;

  task automatic launch(input logic [15:0] ip, cx, si, di);
    ip_in = ip; cx_in = cx; si_in = si; di_in = di; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_done = 0; got_intr = 0; got_unsup = 0;
    for (int i = 0; i < 4000; i++) begin
      if (mem_wr) wr_seen = 1;
      if (done || intr || unsup) begin
        got_done = done; got_intr = intr; got_unsup = unsup;
        return;
      end
      @(negedge clk);
    end
    chk(0, "R12 timeout", 0, 1);
  endtask

  // prog: 0 = F3 A4, 1 = 36 F3 A4, 2 = F3 36 A4, 3 = A4 (no repeat)
  task automatic run_move(input int prog, input int n, input logic d, input int mode,
                          input logic [15:0] si0, input logic [15:0] di0);
    logic [15:0] rep_off, op_off, ip, cx, si, di, soff, doff, sseg, cx0;
    int moves, icnt, exp_i;
    bit rep;
    rep = (prog != 3);
    cx0 = rep ? 16'(n) : 16'd7;
    moves = rep ? n : 1;
    df = d; irq = (mode != 0); ife = (mode == 2);
    case (prog)
      0: begin mwrite(phys(cs, 16'h100), 8'hF3); mwrite(phys(cs, 16'h101), 8'hA4);
               rep_off = 16'h100; op_off = 16'h101; end
      1: begin mwrite(phys(cs, 16'h100), 8'h36); mwrite(phys(cs, 16'h101), 8'hF3);
               mwrite(phys(cs, 16'h102), 8'hA4); rep_off = 16'h101; op_off = 16'h102; end
      2: begin mwrite(phys(cs, 16'h100), 8'hF3); mwrite(phys(cs, 16'h101), 8'h36);
               mwrite(phys(cs, 16'h102), 8'hA4); rep_off = 16'h100; op_off = 16'h102; end
      default: begin mwrite(phys(cs, 16'h100), 8'hA4); rep_off = 16'h0; op_off = 16'h100; end
    endcase
    for (int k = -1; k <= moves; k++) begin
      doff = stepoff(di0, d, k);
      mwrite(phys(es, doff), pat(phys(es, doff)));
    end
    ip = 16'h100; cx = cx0; si = si0; di = di0; icnt = 0;
    for (int r = 0; r < n + 3; r++) begin
      launch(ip, cx, si, di);
      if (!got_intr) break;
      icnt++;
      chk(ip_out == rep_off, "R5 restart at repeat prefix", ip_out, rep_off);
      chk(cx_out == 16'(n - icnt), "R5 count at interrupt", cx_out, n - icnt);
      ip = ip_out; cx = cx_out; si = si_out; di = di_out;
    end
    exp_i = (mode == 2 && rep && n >= 2) ? n - 1 : 0;
    chk(icnt == exp_i, "R9 R10 R6 interrupt count", icnt, exp_i);
    chk(got_done, "R9 R8 done pulse", got_done, 1);
    chk(ip_out == op_off + 16'd1, "R9 next ip", ip_out, op_off + 16'd1);
    chk(cx_out == (rep ? 16'd0 : cx0), "R2 R10 final count", cx_out, rep ? 0 : cx0);
    chk(si_out == stepoff(si0, d, moves), "R3 final si", si_out, stepoff(si0, d, moves));
    chk(di_out == stepoff(di0, d, moves), "R3 final di", di_out, stepoff(di0, d, moves));
    for (int k = 0; k < moves; k++) begin
      sseg = (prog == 0 || prog == 3) ? ds : ((prog == 1 && mode == 2 && k >= 1) ? ds : ss);
      soff = stepoff(si0, d, k);
      doff = stepoff(di0, d, k);
      chk(mem[phys(es, doff)] == pat(phys(sseg, soff)), "R2 R1 R7 moved byte",
          mem[phys(es, doff)], pat(phys(sseg, soff)));
    end
    doff = stepoff(di0, d, moves);
    chk(mem[phys(es, doff)] == pat(phys(es, doff)), "R2 guard after", mem[phys(es, doff)], pat(phys(es, doff)));
    doff = stepoff(di0, d, -1);
    chk(mem[phys(es, doff)] == pat(phys(es, doff)), "R2 guard before", mem[phys(es, doff)], pat(phys(es, doff)));
  endtask

  task automatic run_unsup(input int pre);
    logic [15:0] exp_ip;
    if (pre) begin mwrite(phys(cs, 16'h100), 8'h26); mwrite(phys(cs, 16'h101), 8'h90); exp_ip = 16'h101; end
    else begin mwrite(phys(cs, 16'h100), 8'h90); exp_ip = 16'h100; end
    irq = 0; ife = 0; df = 0; wr_seen = 0;
    launch(16'h100, 16'd4, 16'h0400, 16'h0800);
    chk(got_unsup, "R11 unsup pulse", got_unsup, 1);
    chk(ip_out == exp_ip, "R11 unsup ip", ip_out, exp_ip);
    chk(!wr_seen, "R11 no write", wr_seen, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R12 watchdog act=%0d exp=%0d", 190000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ns [4] = '{0, 1, 2, 5};
    rst_n = 0; start = 0; df = 0; ife = 0; irq = 0;
    ip_in = '0; cx_in = '0; si_in = '0; di_in = '0;
    tb_init = 1;
    @(negedge clk); @(negedge clk);
    tb_init = 0;
    chk(!busy && !done && !intr && !unsup, "R13 reset idle", {busy, done, intr, unsup}, 0);
    chk(!mem_rd && !mem_wr, "R13 reset strobes", {mem_rd, mem_wr}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_rd && !mem_wr, "R12 idle after reset", {busy, mem_rd, mem_wr}, 0);

    for (int p = 0; p < 3; p++)
      for (int i = 0; i < 4; i++)
        for (int d = 0; d < 2; d++)
          for (int m = 0; m < 3; m++)
            run_move(p, ns[i], d[0], m, 16'h0400, 16'h0800);
    for (int d = 0; d < 2; d++) run_move(3, 1, d[0], 2, 16'h0400, 16'h0800);  // R10

    run_move(0, 2, 1'b0, 0, 16'hFFFF, 16'hFFFF);  // R3 wrap up
    run_move(0, 3, 1'b1, 0, 16'h0001, 16'h0001);  // R3 wrap down

    es = 16'hFFFF;                                 // R4 20-bit truncation
    run_move(0, 2, 1'b0, 0, 16'h0400, 16'h0020);
    chk(mem[20'h00010] == pat(phys(ds, 16'h0400)), "R4 truncated address",
        mem[20'h00010], pat(phys(ds, 16'h0400)));
    es = 16'h3000;

    run_unsup(0);
    run_unsup(1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule